// File: doc/BRIEF.md
# Linked-List Command Fetch Engine

This block follows a chain of command nodes kept in a word-addressed system memory and forwards their contents to a command consumer. Every node starts with one header word. The upper byte of the header holds the number of payload words that follow it. The lower 24 bits hold the address of the next node. The engine fetches a header, then the payload words stored right after it, and sends each payload word out on a valid/ready stream. It then jumps to the next node. The chain ends when an address with its top bit (bit 23) set is reached.

Two results are available when a walk finishes. The first is a cost figure: each visited node adds five plus its payload count. The second is the address at which the walk stopped. The number of visited nodes is capped. A chain that would go past the cap, such as one that points back on itself, is cut off and reported with an error flag.

The memory port issues one read at a time, and data returns after a fixed number of cycles. A host starts a walk with a one-cycle `start` pulse and waits for the one-cycle `done` pulse.

Top module: `llw_walker`

## Requirements
- R1: On `start` in idle, the walk address becomes `start_addr[23:0]`. Whenever the current address has bit 23 set, the walk ends without reading it, and `progress` shows that 24-bit address.
- R2: A header word is decoded as payload count = bits 31:24 and next node address = bits 23:0.
- R3: Every read uses word index `mem_addr = (addr & 0x1FFFFF) >> 2`, so addresses that differ only in bits 23:21 read the same word.
- R4: Payload words are read from header address +4, +8, ... and leave on `cmd_data` in chain order, each exactly once. A count of 0 produces no word.
- R5: `cost` is cleared at start and grows by 5 + count for every header read.
- R6: If NODE_LIMIT (default 8192) headers have been read and the current address still lacks bit 23, the walk ends with `loop_err`=1 and `progress` = that address. Otherwise `loop_err`=0.
- R7: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` does not change.
- R8: `done` is high for exactly one cycle, only after the last payload word has been accepted. In the following cycle `busy` is low. `cmd_valid` is never high while `busy` is low.
- R9: A `start` pulse while `busy` is high is ignored. The running walk completes with its own results.
- R10: At most one read is in flight. `mem_rdata` is taken RD_LAT cycles after the cycle in which `mem_req` was high, and `mem_req` is never high in two consecutive cycles.
- R11: After reset, `busy`, `done`, `loop_err`, `mem_req` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| start_addr | input | 32 | Address of the first node; upper byte ignored |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| loop_err | output | 1 | Last walk was cut off by the node cap |
| progress | output | 24 | Address where the last walk stopped |
| cost | output | COST_W | Accumulated node cost of the current or last walk |
| mem_req | output | 1 | Read request |
| mem_addr | output | MEM_AW | Word index of the read |
| mem_rdata | input | 32 | Read data, RD_LAT cycles after the request |
| cmd_valid | output | 1 | Payload word available |
| cmd_ready | input | 1 | Consumer accepts the word |
| cmd_data | output | 32 | Payload word |

## Verification
The hardest case to reach from the ports is the node cap. It only fires after thousands of headers have been read, and only when no terminator appears. The bench reaches it with a single node whose next pointer is its own address and whose payload is empty. This case runs at the default cap, so the exact cost (five per node) and the reported stop address can be checked. A second hard case is a stall on the last payload word, which tests that `done` waits for the hand-off. A pseudo-random `cmd_ready` pattern creates stalls inside and at the end of nodes, while a behavioural model walks the same memory and checks every accepted word as it leaves.

// File: rtl/llw_pkg.sv
package llw_pkg;
  localparam int ADDR_W = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_HREQ, S_HWAIT, S_PREQ, S_PWAIT, S_FIN
  } walk_state_e;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [31:0] raw);
    return ADDR_W'(raw & 32'h00FF_FFFF);
  endfunction

  function automatic logic is_terminal(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  function automatic logic [ADDR_W-1:0] word_index(input logic [ADDR_W-1:0] a);
    return (a & 24'h1F_FFFF) >> 2;
  endfunction

  function automatic logic [7:0] hdr_count(input logic [31:0] w);
    return w[31:24];
  endfunction

  function automatic logic [ADDR_W-1:0] hdr_link(input logic [31:0] w);
    return w[23:0];
  endfunction

  function automatic logic [31:0] node_cost(input logic [7:0] cnt);
    return 32'd5 + 32'(cnt);
  endfunction
endpackage

// File: rtl/llw_lat_pipe.sv
module llw_lat_pipe #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rvalid
);
  generate
    if (RD_LAT == 1) begin : g_one
      logic sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= 1'b0;
        else        sr <= req;
      end
      assign rvalid = sr;
    end else begin : g_many
      logic [RD_LAT-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[RD_LAT-2:0], req};
      end
      assign rvalid = sr[RD_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/llw_out_slot.sv
module llw_out_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/llw_walker.sv
module llw_walker
  import llw_pkg::*;
#(
  parameter int MEM_AW     = 19,
  parameter int RD_LAT     = 2,
  parameter int NODE_LIMIT = 8192,
  parameter int COST_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  output logic              busy,
  output logic              done,
  output logic              loop_err,
  output logic [23:0]       progress,
  output logic [COST_W-1:0] cost,
  output logic              mem_req,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [31:0]       cmd_data
);
  localparam int NODE_W = $clog2(NODE_LIMIT + 1);

  walk_state_e       state;
  logic [ADDR_W-1:0] cur_addr, next_addr, pay_addr;
  logic [7:0]        remain;
  logic [NODE_W-1:0] nodes;
  logic              rvalid;

  // named events for the checker and for reading the code
  logic hdr_fire, word_fire, stop_end, stop_loop, stop_ok;
  logic [ADDR_W-1:0] rd_ptr, rd_index;

  assign stop_end  = (state == S_CHECK) && is_terminal(cur_addr);
  assign stop_loop = (state == S_CHECK) && !is_terminal(cur_addr) &&
                     (nodes == NODE_W'(NODE_LIMIT));
  assign stop_ok   = (stop_end || stop_loop) && !cmd_valid;
  assign hdr_fire  = (state == S_HWAIT) && rvalid;
  assign word_fire = (state == S_PWAIT) && rvalid;

  assign mem_req   = (state == S_HREQ) || ((state == S_PREQ) && !cmd_valid);
  assign rd_ptr    = (state == S_HREQ) ? cur_addr : pay_addr;
  assign rd_index  = word_index(rd_ptr);
  assign mem_addr  = MEM_AW'(rd_index);
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_FIN);

  llw_lat_pipe #(.RD_LAT(RD_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .req(mem_req), .rvalid(rvalid)
  );

  llw_out_slot #(.DW(32)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(word_fire), .load_data(mem_rdata),
    .ready(cmd_ready), .valid(cmd_valid), .data(cmd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur_addr  <= '0;
      next_addr <= '0;
      pay_addr  <= '0;
      remain    <= '0;
      nodes     <= '0;
      cost      <= '0;
      loop_err  <= 1'b0;
      progress  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          cur_addr <= entry_addr(start_addr);
          nodes    <= '0;
          cost     <= '0;
          loop_err <= 1'b0;
          state    <= S_CHECK;
        end
        S_CHECK: begin
          if (stop_ok) begin
            progress <= cur_addr;
            loop_err <= stop_loop;
            state    <= S_FIN;
          end else if (!stop_end && !stop_loop) begin
            state <= S_HREQ;
          end
        end
        S_HREQ: state <= S_HWAIT;
        S_HWAIT: if (hdr_fire) begin
          next_addr <= hdr_link(mem_rdata);
          remain    <= hdr_count(mem_rdata);
          pay_addr  <= cur_addr + ADDR_W'(4);
          cost      <= cost + COST_W'(node_cost(hdr_count(mem_rdata)));
          nodes     <= nodes + 1'b1;
          if (hdr_count(mem_rdata) == 8'd0) begin
            cur_addr <= hdr_link(mem_rdata);
            state    <= S_CHECK;
          end else begin
            state <= S_PREQ;
          end
        end
        S_PREQ: if (!cmd_valid) state <= S_PWAIT;
        S_PWAIT: if (word_fire) begin
          pay_addr <= pay_addr + ADDR_W'(4);
          remain   <= remain - 8'd1;
          if (remain == 8'd1) begin
            cur_addr <= next_addr;
            state    <= S_CHECK;
          end else begin
            state <= S_PREQ;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/llw_checker.sv
module llw_checker #(
  parameter int NODE_LIMIT = 8192,
  parameter int COST_W     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              loop_err,
  input logic [23:0]       progress,
  input logic [COST_W-1:0] cost,
  input logic              mem_req,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [31:0]       cmd_data,
  input logic              hdr_fire,
  input logic              word_fire
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R8
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !mem_req); // R8
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R10
  AST_END_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    done && !loop_err |-> progress[23]); // R1
  AST_LOOP_COST: assert property (@(posedge clk) disable iff (!rst_n)
    done && loop_err |-> (64'(cost) >= 64'(NODE_LIMIT) * 64'd5)); // R6
  AST_FETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire || word_fire |-> busy && !done); // R10
endmodule

bind llw_walker llw_checker #(.NODE_LIMIT(NODE_LIMIT), .COST_W(COST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .loop_err(loop_err),
  .progress(progress), .cost(cost), .mem_req(mem_req), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_data(cmd_data), .hdr_fire(hdr_fire),
  .word_fire(word_fire)
);

// File: tb/tb_llw_walker.sv
`timescale 1ns/1ps
module tb_llw_walker;
  localparam int MEM_AW = 19;
  localparam int RD_LAT = 2;
  localparam int LIMIT  = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, done, loop_err, mem_req, cmd_valid, cmd_data_unused;
  logic [23:0] progress;
  logic [31:0] cost, cmd_data, mem_rdata;
  logic [MEM_AW-1:0] mem_addr;
  logic        cmd_ready = 1'b1;

  always #2.5 clk = ~clk;

  llw_walker #(.MEM_AW(MEM_AW), .RD_LAT(RD_LAT), .NODE_LIMIT(LIMIT), .COST_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .loop_err(loop_err), .progress(progress),
    .cost(cost), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );
  assign cmd_data_unused = 1'b0;

  int total = 0;
  int bad   = 0;

  // sparse memory, fixed-latency read
  logic [31:0] mem [int];
  logic [31:0] stg [RD_LAT];
  function automatic logic [31:0] rd(input int idx);
    return mem.exists(idx) ? mem[idx] : 32'h0;
  endfunction
  function automatic int idx_of(input logic [31:0] a);
    return int'((a & 32'h001F_FFFF) >> 2);
  endfunction
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    mem[idx_of(a)] = d;
  endtask
  always @(posedge clk) begin
    stg[0] <= mem_req ? rd(int'(mem_addr)) : 32'hBAD0_BAD0;
    for (int k = 1; k < RD_LAT; k++) stg[k] <= stg[k-1];
  end
  assign mem_rdata = stg[RD_LAT-1];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model: walks memory behaviourally
  logic [31:0] exp_q[$];
  longint      exp_cost;
  logic [23:0] exp_prog;
  bit          exp_loop;
  task automatic model_walk(input logic [31:0] sa);
    logic [31:0] a, h;
    int n, c;
    exp_q.delete();
    a = sa & 32'h00FF_FFFF;
    n = 0;
    exp_cost = 0;
    while (a[23] == 1'b0 && n < LIMIT) begin
      h = rd(idx_of(a));
      c = int'(h >> 24);
      for (int i = 1; i <= c; i++) exp_q.push_back(rd(idx_of(a + 32'(4 * i))));
      exp_cost += 5 + c;
      n++;
      a = h & 32'h00FF_FFFF;
    end
    exp_loop = (a[23] == 1'b0);
    exp_prog = a[23:0];
  endtask

  // per-cycle monitor: stream, stall rule, done pulse
  bit          bp_on = 1'b0;
  int unsigned lfsr  = 32'h1234_5678;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_data;
  bit          prev_done = 1'b0;
  int          words_seen;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(cmd_valid && cmd_data == prev_data, "R7", "held word",
              longint'(cmd_data), longint'(prev_data));
      if (prev_done)
        check(!done && !busy, "R8", "after done", longint'({done, busy}), 0);
      if (!busy && cmd_valid)
        check(1'b0, "R8", "valid while idle", 1, 0);
      lfsr = lfsr * 1103515245 + 12345;
      cmd_ready = !bp_on || lfsr[16];
      if (cmd_valid && cmd_ready) begin
        words_seen++;
        if (exp_q.size() == 0) check(1'b0, "R4", "extra word", longint'(cmd_data), 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(cmd_data == e, "R4", "payload word", longint'(cmd_data), longint'(e));
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_data  = cmd_data;
      prev_done  = done;
    end
  end

  // run one walk and compare the end results
  task automatic run_walk(input logic [31:0] sa, input string tag,
                          input bit poke_mid, input int exp_first_idx);
    int cyc;
    bit got_first;
    model_walk(sa);
    words_seen = 0;
    @(negedge clk);
    start = 1'b1; start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R8", {tag, " busy after start"}, longint'(busy), 1);
    cyc = 0;
    got_first = 1'b0;
    while (!done && cyc < 60000) begin
      if (mem_req && !got_first && exp_first_idx >= 0) begin
        got_first = 1'b1;
        check(int'(mem_addr) == exp_first_idx, "R3", {tag, " first index"},
              longint'(mem_addr), longint'(exp_first_idx));
      end
      if (poke_mid && cyc == 6) begin
        start = 1'b1; start_addr = 32'h0080_0000;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check(done, "R8", {tag, " done seen"}, longint'(done), 1);
    check(cost == 32'(exp_cost), "R5", {tag, " cost"}, longint'(cost), exp_cost);
    check(progress == exp_prog, "R1", {tag, " progress"}, longint'(progress), longint'(exp_prog));
    check(loop_err == exp_loop, "R6", {tag, " loop flag"}, longint'(loop_err), longint'(exp_loop));
    check(exp_q.size() == 0, "R4", {tag, " words left"}, longint'(exp_q.size()), 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check({busy, done, loop_err, mem_req, cmd_valid} == 5'b0, "R11", "reset outputs",
          longint'({busy, done, loop_err, mem_req, cmd_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req, "R11", "idle after reset", longint'({busy, mem_req}), 0);

    // R1: terminal start address, upper byte dropped; no reads
    run_walk(32'hFF80_0010, "term", 1'b0, -1);
    check(words_seen == 0, "R1", "no words on terminal start", longint'(words_seen), 0);

    // R2 R4 R5: three nodes incl an empty one, no back-pressure
    mem.delete();
    wr(32'h1000, {8'd3, 24'h002000});
    wr(32'h1004, 32'h1111_0001); wr(32'h1008, 32'h2222_0002); wr(32'h100C, 32'h3333_0003);
    wr(32'h2000, {8'd0, 24'h003000});
    wr(32'h3000, {8'd2, 24'hFFFFFF});
    wr(32'h3004, 32'hA5A5_0004); wr(32'h3008, 32'h5A5A_0005);
    run_walk(32'hAB00_1000, "chain", 1'b0, 32'h1000 >> 2);
    check(words_seen == 5, "R4", "word count", longint'(words_seen), 5);

    // R7: same chain under random back-pressure
    bp_on = 1'b1;
    run_walk(32'h0000_1000, "chain_bp", 1'b0, 32'h1000 >> 2);

    // R9: start pulse mid-walk is ignored
    run_walk(32'h0000_1000, "restart", 1'b1, 32'h1000 >> 2);
    bp_on = 1'b0;

    // R3: alias above 2 MB
    mem.delete();
    wr(32'h0000_0100, {8'd1, 24'hA00000});
    wr(32'h0000_0104, 32'hCAFE_F00D);
    run_walk(32'h0020_0100, "alias", 1'b0, 32'h100 >> 2);

    // R2: maximum payload count with back-pressure
    mem.delete();
    wr(32'h8000, {8'd255, 24'h800000});
    for (int i = 1; i <= 255; i++) wr(32'h8000 + 32'(4 * i), 32'(i * 32'h0101_0101));
    bp_on = 1'b1;
    run_walk(32'h0000_8000, "maxcnt", 1'b0, 32'h8000 >> 2);
    bp_on = 1'b0;
    check(words_seen == 255, "R2", "255 words", longint'(words_seen), 255);

    // R6: self-loop hits the node cap
    mem.delete();
    wr(32'h4000, {8'd0, 24'h004000});
    run_walk(32'h0000_4000, "loop", 1'b0, 32'h4000 >> 2);
    check(cost == 32'(5 * LIMIT), "R6", "loop cost", longint'(cost), longint'(5 * LIMIT));

    // R6: a following good walk clears the flag
    mem.delete();
    wr(32'h500, {8'd0, 24'h900000});
    run_walk(32'h0000_0500, "clear", 1'b0, 32'h500 >> 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule